// File: doc/BRIEF.md
# Unsigned 32-by-16 Divide Unit

This block divides an unsigned 32-bit dividend by an unsigned 16-bit divisor, one quotient bit per clock. It is meant as the divide engine of a 16-bit processor datapath. Instruction decode and register-file access sit outside it. A single-cycle `start` strobe loads the operands and the incoming condition-code group. `busy` then stays high for sixteen iteration cycles. A one-cycle `done` pulse marks the moment the packed result and the outgoing flags become valid. Both then hold until the next accepted start.

The result word carries the quotient in its low half and the remainder in its high half. Two flags depend only on the divisor. N copies the divisor's top bit, and Z reports a zero divisor. The other three flags (H, V, C) leave the block exactly as they came in. The block detects neither a zero divisor nor a quotient that overflows 16 bits. In both cases it still finishes in the normal time and returns whatever pattern the iteration produces.

The handshake is plain control: `start` is accepted only while `busy` is low. A `start` raised while `busy` is high is dropped without effect. The caller must hold it off, or re-issue it after `done`.

Top module: `udiv32x16`

## Requirements
- R1: When the upper 16 dividend bits are below a nonzero divisor, `result[15:0]` at `done` equals the unsigned quotient dividend / divisor.
- R2: Under the same condition, `result[31:16]` at `done` equals the unsigned remainder dividend mod divisor.
- R3: Flag vectors use bit 4 = H, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. At `done`, `flags_out[3]` equals bit 15 of the divisor captured at start.
- R4: At `done`, `flags_out[2]` is 1 if the captured divisor is zero and 0 otherwise.
- R5: At `done`, `flags_out[4]`, `flags_out[1]` and `flags_out[0]` equal bits 4, 1 and 0 of `flags_in` sampled at the accepted start.
- R6: A start is accepted on a rising edge where `start` is 1 and `busy` is 0. `busy` is 1 from the next cycle onward, and `done` pulses for exactly one cycle after the 16th following edge. In that cycle `busy` is 0, and `busy` and `done` are never high together.
- R7: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its timing, its result and its flags.
- R8: A zero divisor, or a quotient too wide for 16 bits, still completes with the R6 timing and never hangs. The result value is not defined in these cases.
- R9: Synchronous active-high `rst` clears `busy`, `done`, `result` and `flags_out` to 0, including in the middle of an operation.
- R10: `result` and `flags_out` hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load operands and begin a divide (ignored while busy) |
| dividend | input | 32 | Unsigned dividend |
| divisor | input | 16 | Unsigned divisor |
| flags_in | input | 5 | Incoming flags {H,N,Z,V,C} |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | {remainder, quotient} |
| flags_out | output | 5 | Outgoing flags {H,N,Z,V,C} |

## Verification
The bench checks the done latency cycle by cycle. A counter off by one would move the `done` pulse to the wrong sampled cycle. It fires `start` with different operands in the middle of a divide. A design that reloads on such a pulse would return the wrong quotient or finish late. It drives a zero divisor and dividends whose high half reaches the divisor. A design that stalls or mishandles Z in these cases would hang the watchdog or report a wrong flag. It also uses divisors with the top bit set, the value 1 and the value 0xFFFF, together with a reset in the middle of an operation. These expose a lost 17th bit in the trial subtraction, a wrong N source, and state that survives reset.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
  parameter int ITER = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic last
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign load = start && !busy_q;
  assign step = busy_q;
  assign last = busy_q && (cnt_q == CW'(ITER - 1));
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q); // R6
  AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk) disable iff (rst) !(busy_q && done_q)); // R6
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst) (start && !busy_q) |=> busy_q); // R6
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst) busy_q |-> (int'(cnt_q) < ITER)); // R8
  AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (rst) (busy_q && !last) |=> busy_q); // R7
endmodule

// File: rtl/udiv_step.sv
module udiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem_in, quo_in[W-1]};
    diff    = shifted - {1'b0, dvs};
    fits    = (shifted >= {1'b0, dvs});
    rem_out = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_out = {quo_in[W-2:0], fits};
  end
endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   dvs_held,
  output logic [2*W-1:0] packed_res
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W-1:0] rem_nxt, quo_nxt;

  udiv_step #(.W(W)) u_step (
    .rem_in (rem_q),
    .quo_in (quo_q),
    .dvs    (dvs_q),
    .rem_out(rem_nxt),
    .quo_out(quo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= dividend[2*W-1:W];
      quo_q <= dividend[W-1:0];
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
    end
  end

  assign dvs_held   = dvs_q;
  assign packed_res = {rem_q, quo_q};

  AST_REM_STAYS_BELOW: assert property (@(posedge clk) disable iff (rst)
    (step && !load && dvs_q != '0 && rem_q < dvs_q) |=> (rem_q < dvs_q)); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(rem_q) && $stable(quo_q))); // R10
  AST_DIVISOR_KEPT: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dvs_q)); // R7
endmodule

// File: rtl/udiv_ccr.sv
module udiv_ccr
  import udiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         last,
  input  logic [W-1:0] divisor,
  input  logic         h_in,
  input  logic         v_in,
  input  logic         c_in,
  output ccr_t         ccr_out
);
  ccr_t pend_q, out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      out_q  <= '0;
    end else begin
      if (load) begin
        pend_q.h <= h_in;
        pend_q.v <= v_in;
        pend_q.c <= c_in;
        pend_q.n <= divisor[W-1];
        pend_q.z <= (divisor == '0);
      end
      if (last) out_q <= pend_q;
    end
  end

  assign ccr_out = out_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) !last |=> $stable(out_q)); // R10
endmodule

// File: rtl/udiv32x16.sv
module udiv32x16
  import udiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic [4:0]     flags_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] result,
  output logic [4:0]     flags_out
);
  localparam int ITER = W;

  logic         load, step, last;
  logic [W-1:0] dvs_held;
  ccr_t         ccr_in, ccr_q;
  logic         unused_nz_in;

  assign ccr_in       = ccr_t'(flags_in);
  assign unused_nz_in = ccr_in.n ^ ccr_in.z;

  udiv_ctrl #(.ITER(ITER)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .done (done),
    .load (load),
    .step (step),
    .last (last)
  );

  udiv_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .dividend  (dividend),
    .divisor   (divisor),
    .dvs_held  (dvs_held),
    .packed_res(result)
  );

  udiv_ccr #(.W(W)) u_ccr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .last   (last),
    .divisor(divisor),
    .h_in   (ccr_in.h),
    .v_in   (ccr_in.v),
    .c_in   (ccr_in.c),
    .ccr_out(ccr_q)
  );

  assign flags_out = ccr_q;

  AST_N_FROM_DIVISOR: assert property (@(posedge clk) disable iff (rst) done |-> (ccr_q.n == dvs_held[W-1])); // R3
  AST_Z_FROM_DIVISOR: assert property (@(posedge clk) disable iff (rst) done |-> (ccr_q.z == (dvs_held == '0))); // R4
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done && result == '0 && flags_out == '0)); // R9
endmodule

// File: tb/udiv32x16_bench.sv
module udiv32x16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [4:0]  flags_in = '0;
  logic        busy, done;
  logic [31:0] result;
  logic [4:0]  flags_out;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  udiv32x16 u_udiv32x16 (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .flags_in(flags_in), .busy(busy), .done(done), .result(result), .flags_out(flags_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_quo(input logic [31:0] a, input logic [15:0] b);
    logic [31:0] q = a / {16'd0, b};
    return q[15:0];
  endfunction

  function automatic logic [15:0] ref_rem(input logic [31:0] a, input logic [15:0] b);
    logic [31:0] r = a % {16'd0, b};
    return r[15:0];
  endfunction

  function automatic logic [4:0] ref_flags(input logic [4:0] fin, input logic [15:0] b);
    return {fin[4], b[15], (b == 16'd0), fin[1], fin[0]};
  endfunction

  // Runs one divide. Latency: done first seen at the 17th negedge after start is raised.
  task automatic run_div(input logic [31:0] a, input logic [15:0] b, input logic [4:0] fin,
                         input bit poke);
    int n;
    bit val;
    logic [31:0] held;
    logic [4:0]  held_f;
    val = (b != 16'd0) && (a[31:16] < b);
    @(negedge clk);
    dividend = a; divisor = b; flags_in = fin; start = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 1'b0;
        chk(busy === 1'b1, "R6", "busy after accepted start", {31'd0, busy}, 32'd1);
      end
      if (poke && n == 4) begin
        dividend = ~a; divisor = b ^ 16'h5a5b; flags_in = ~fin; start = 1'b1;
      end
      if (poke && n == 5) start = 1'b0;
      if (done === 1'b1 || n >= 40) break;
      if (n > 1 && busy !== 1'b1) begin
        chk(1'b0, "R6", "busy dropped early", {31'd0, busy}, 32'd1);
        break;
      end
    end
    chk(n == 17, val ? "R6" : "R8", "done latency", n, 17);
    chk(busy === 1'b0, "R6", "busy low with done", {31'd0, busy}, 32'd0);
    if (val) begin
      chk(result[15:0] === ref_quo(a, b), poke ? "R7" : "R1", "quotient",
          {16'd0, result[15:0]}, {16'd0, ref_quo(a, b)});
      chk(result[31:16] === ref_rem(a, b), poke ? "R7" : "R2", "remainder",
          {16'd0, result[31:16]}, {16'd0, ref_rem(a, b)});
    end
    chk(flags_out[3] === b[15], "R3", "N flag", {31'd0, flags_out[3]}, {31'd0, b[15]});
    chk(flags_out[2] === (b == 16'd0), "R4", "Z flag", {31'd0, flags_out[2]}, {31'd0, (b == 16'd0)});
    chk({flags_out[4], flags_out[1:0]} === {fin[4], fin[1:0]}, poke ? "R7" : "R5", "H/V/C pass",
        {27'd0, flags_out}, {27'd0, ref_flags(fin, b)});
    held = result; held_f = flags_out;
    dividend = $urandom; divisor = 16'($urandom);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done is single cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(result === held, "R10", "result held", result, held);
    chk(flags_out === held_f, "R10", "flags held", {27'd0, flags_out}, {27'd0, held_f});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R9", "idle after reset", {30'd0, busy, done}, 32'd0);
    chk(result === 32'd0, "R9", "result after reset", result, 32'd0);
    chk(flags_out === 5'd0, "R9", "flags after reset", {27'd0, flags_out}, 32'd0);

    run_div(32'd100, 16'd7, 5'b10011, 0);
    run_div(32'h0000_ffff, 16'd1, 5'b01100, 0);
    run_div(32'hfffe_ffff, 16'hffff, 5'b00000, 0);
    run_div(32'h8000_0000, 16'h8001, 5'b10010, 0);
    run_div(32'h0000_0005, 16'h0009, 5'b00001, 0);
    run_div(32'h1234_5678, 16'h4321, 5'b10101, 1);
    run_div(32'h0001_0000, 16'h0000, 5'b11111, 0);
    run_div(32'h1234_5678, 16'h0010, 5'b00010, 0);

    for (int i = 0; i < 60; i++) begin
      logic [15:0] b, hi, lo;
      b  = 16'($urandom);
      if (b == 16'd0) b = 16'd3;
      if (i % 3 == 0) b[15] = 1'b1;
      hi = 16'($urandom % {16'd0, b});
      lo = 16'($urandom);
      run_div({hi, lo}, b, 5'($urandom), (i % 7) == 0);
    end

    // Reset in the middle of a divide.
    @(negedge clk);
    dividend = 32'h0042_0042; divisor = 16'h0100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && done === 1'b0, "R9", "idle after mid-op reset", {30'd0, busy, done}, 32'd0);
    chk(result === 32'd0, "R9", "result after mid-op reset", result, 32'd0);
    repeat (20) @(negedge clk);
    chk(done === 1'b0, "R9", "no done after aborted op", {31'd0, done}, 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule